// File: doc/BRIEF.md
# Page Translation Cache with Global Entries

This block is a small, fully associative cache of recent page translations. It sits in front of a page walker. A lookup presents a 32-bit linear address. One cycle later the block reports a hit or a miss. On a hit it also gives the physical address and the stored permission field, so the caller can run the same fault checks it would run after a walk. After a miss the walker writes the result back through the fill port. Entries are either 4 KB pages or large pages. A large page is selected by the ten most significant address bits alone.

The cache has three invalidation paths. Every pulse on the directory-base write input removes all entries that are not marked global. Global entries stay resident until the global-enable input falls. A single linear address can also be invalidated, which removes only the entry that translates it. A full flush therefore takes three steps: clear global-enable, pulse the base write, set global-enable again. New entries go into slots chosen round-robin. A fill of a page that is already resident updates that entry in place.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, `rsp_valid` and `rsp_hit` are 0, and any lookup misses.
- R2: A lookup sampled with `lk_valid`=1 at a clock edge is answered by `rsp_valid`=1 and `rsp_hit` after that same edge. The first lookup of a page misses, and the same page hits once it has been filled.
- R3: For a 4 KB entry, `rsp_paddr` is the stored 20-bit frame number in bits 31:12 followed by linear address bits 11:0.
- R4: A large entry (`fill_large`=1) matches on linear address bits 31:22 only. Its `rsp_paddr` is the stored frame bits 19:10 in bits 31:22 followed by linear address bits 21:0.
- R5: A hit returns the 3-bit permission field stored at fill time, unchanged.
- R6: Each `root_wr` pulse invalidates every entry whose global bit is 0. Entries with the global bit set stay valid.
- R7: A 1-to-0 transition of `glob_en` invalidates every global entry and leaves non-global entries valid.
- R8: A fill made while `glob_en` is 0 stores its global bit as 0, so the next `root_wr` removes it.
- R9: The sequence clear `glob_en`, pulse `root_wr`, set `glob_en` leaves no valid entry.
- R10: An `inv_valid` pulse removes only the entry that translates `inv_va`. Other entries keep hitting.
- R11: An invalidate of any address within a large entry's 4 MB range removes that entry.
- R12: When an invalidate and a fill for the same page arrive in one cycle, the page is not left valid. A fill and an invalidate of different pages in one cycle keep the filled entry.
- R13: Fills of new pages take slots in round-robin order starting at slot 0 after reset. With ENTRIES=8, the ninth distinct fill evicts the first page and keeps the second.
- R14: A fill of a page that is already resident (same page number and size) overwrites that entry in place and does not use a new slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Linear address to translate |
| rsp_valid | output | 1 | Response to the previous cycle's lookup |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_perm | output | 3 | Stored permission field |
| rsp_large | output | 1 | Hit entry is a large page |
| fill_valid | input | 1 | Write a walk result |
| fill_vpn | input | 20 | Linear page number (bits 31:12) |
| fill_frame | input | 20 | Physical frame number |
| fill_perm | input | 3 | Permission field |
| fill_large | input | 1 | Entry maps a large page |
| fill_global | input | 1 | Entry is global |
| root_wr | input | 1 | Directory-base register written |
| glob_en | input | 1 | Global-enable control level |
| inv_valid | input | 1 | Single-address invalidate |
| inv_va | input | 32 | Address to invalidate |

## Verification
Fills can coincide with any of the three invalidation paths. The case that matters most is a fill and a single-address invalidate of the same page in the same clock cycle. The bench forces this by driving both ports in one cycle. It then checks with a lookup that the page misses, and it repeats the cycle with two different pages to show the fill survives. A fill in the same cycle as a base write is covered by an assertion. That assertion requires the new entry to be killed unless it is global.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int LRG_W  = 10;
  localparam int FRM_W  = 20;
  localparam int PA_W   = FRM_W + OFF_W;
  localparam int PERM_W = 3;

  typedef struct packed {
    logic              vld;
    logic              glb;
    logic              lrg;
    logic [PERM_W-1:0] perm;
    logic [VPN_W-1:0]  vpn;
    logic [FRM_W-1:0]  frm;
  } ent_t;

  // Does a valid entry translate this linear address?
  function automatic logic page_hit(input ent_t e, input logic [VA_W-1:0] va);
    logic same;
    if (e.lrg) same = (e.vpn[VPN_W-1 -: LRG_W] == va[VA_W-1 -: LRG_W]);
    else       same = (e.vpn == va[VA_W-1:OFF_W]);
    return e.vld && same;
  endfunction

  // Physical address formed from an entry and a linear address.
  function automatic logic [PA_W-1:0] make_pa(input ent_t e, input logic [VA_W-1:0] va);
    if (e.lrg) return {e.frm[FRM_W-1 -: LRG_W], va[VA_W-LRG_W-1:0]};
    else       return {e.frm, va[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/xc_match.sv
module xc_match
  import xc_pkg::*;
#(
  parameter int N = 8
) (
  input  ent_t [N-1:0]    ents,
  input  logic [VA_W-1:0] va,
  output logic [N-1:0]    hit_vec,
  output ent_t            sel
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = page_hit(ents[g], va);
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec[i]) sel = sel | ents[i];
  end
endmodule

// File: rtl/xc_rr.sv
module xc_rr #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/xc_store.sv
module xc_store
  import xc_pkg::*;
#(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ent_t             wr_ent,
  input  logic             root_wr,
  input  logic             ge_fall,
  input  logic             inv_valid,
  input  logic [VA_W-1:0]  inv_va,
  output ent_t [N-1:0]     ents
);
  ent_t [N-1:0] ent_n;
  logic [N-1:0] wr_here;

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign wr_here[g] = wr_en && (wr_idx == IDX_W'(g));

    // Kill terms are applied to the post-write content so that an
    // invalidate in the same cycle as a fill wins.
    always_comb begin
      ent_t e;
      logic kill;
      e = ents[g];
      if (wr_here[g]) e = wr_ent;
      kill = (root_wr && !e.glb) || (ge_fall && e.glb) ||
             (inv_valid && page_hit(e, inv_va));
      if (kill) e.vld = 1'b0;
      ent_n[g] = e;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ents[g] <= '0;
      else        ents[g] <= ent_n[g];
    end

    a_r6_root_drops_local: assert property (@(posedge clk) disable iff (!rst_n)
      root_wr && !wr_here[g] && ents[g].vld && !ents[g].glb |=> !ents[g].vld);

    a_r6_root_keeps_global: assert property (@(posedge clk) disable iff (!rst_n)
      root_wr && !wr_here[g] && !ge_fall && !(inv_valid && page_hit(ents[g], inv_va))
      && ents[g].vld && ents[g].glb |=> ents[g].vld);

    a_r7_clear_drops_global: assert property (@(posedge clk) disable iff (!rst_n)
      ge_fall && !wr_here[g] && ents[g].vld && ents[g].glb |=> !ents[g].vld);

    a_r12_inv_beats_fill: assert property (@(posedge clk) disable iff (!rst_n)
      wr_here[g] && inv_valid && page_hit(wr_ent, inv_va) |=> !ents[g].vld);

    a_r12_root_beats_local_fill: assert property (@(posedge clk) disable iff (!rst_n)
      wr_here[g] && root_wr && !wr_ent.glb |=> !ents[g].vld);
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xc_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [31:0]       lk_va,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [31:0]       rsp_paddr,
  output logic [2:0]        rsp_perm,
  output logic              rsp_large,
  input  logic              fill_valid,
  input  logic [19:0]       fill_vpn,
  input  logic [19:0]       fill_frame,
  input  logic [2:0]        fill_perm,
  input  logic              fill_large,
  input  logic              fill_global,
  input  logic              root_wr,
  input  logic              glob_en,
  input  logic              inv_valid,
  input  logic [31:0]       inv_va
);
  ent_t [ENTRIES-1:0] ents;
  logic               glob_en_q;
  logic               ge_fall;
  logic [ENTRIES-1:0] lk_vec, fl_vec, dup_vec;
  ent_t               lk_sel, fl_sel;
  logic               dup_any;
  logic [IDX_W-1:0]   dup_idx, rr_ptr, wr_idx;
  ent_t               wr_ent;
  logic [VA_W-1:0]    fill_va;

  // Global-enable edge tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) glob_en_q <= 1'b0;
    else        glob_en_q <= glob_en;
  end
  assign ge_fall = glob_en_q && !glob_en;

  // Lookup compare bank
  xc_match #(.N(ENTRIES)) u_lk_match (
    .ents(ents), .va(lk_va), .hit_vec(lk_vec), .sel(lk_sel)
  );

  // Resident-page detection for the fill
  assign fill_va = {fill_vpn, {OFF_W{1'b0}}};
  xc_match #(.N(ENTRIES)) u_fl_match (
    .ents(ents), .va(fill_va), .hit_vec(fl_vec), .sel(fl_sel)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_dup
    assign dup_vec[g] = fl_vec[g] && (ents[g].lrg == fill_large);
  end
  assign dup_any = |dup_vec;

  always_comb begin
    dup_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (dup_vec[i]) dup_idx = IDX_W'(i);
  end

  xc_rr #(.N(ENTRIES)) u_rr (
    .clk(clk), .rst_n(rst_n), .adv(fill_valid && !dup_any), .ptr(rr_ptr)
  );

  assign wr_idx = dup_any ? dup_idx : rr_ptr;

  always_comb begin
    wr_ent      = '0;
    wr_ent.vld  = 1'b1;
    wr_ent.glb  = fill_global && glob_en;
    wr_ent.lrg  = fill_large;
    wr_ent.perm = fill_perm;
    wr_ent.vpn  = fill_vpn;
    wr_ent.frm  = fill_frame;
  end

  xc_store #(.N(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(fill_valid), .wr_idx(wr_idx), .wr_ent(wr_ent),
    .root_wr(root_wr), .ge_fall(ge_fall), .inv_valid(inv_valid), .inv_va(inv_va),
    .ents(ents)
  );

  // Registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
      rsp_large <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && (|lk_vec);
      rsp_paddr <= make_pa(lk_sel, lk_va);
      rsp_perm  <= lk_sel.perm;
      rsp_large <= lk_sel.lrg;
    end
  end

  a_r2_hit_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  a_r2_response_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    a_r8_global_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      ents[g].vld && ents[g].glb |-> glob_en_q);
  end
endmodule

// File: tb/test_xlat_cache.sv
module test_xlat_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_va = '0;
  logic        rsp_valid, rsp_hit, rsp_large;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_perm;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0, fill_frame = '0;
  logic [2:0]  fill_perm = '0;
  logic        fill_large = 1'b0, fill_global = 1'b0;
  logic        root_wr = 1'b0, glob_en = 1'b1, inv_valid = 1'b0;
  logic [31:0] inv_va = '0;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xlat_cache i_xlat_cache (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .rsp_perm(rsp_perm), .rsp_large(rsp_large),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_frame(fill_frame),
    .fill_perm(fill_perm), .fill_large(fill_large), .fill_global(fill_global),
    .root_wr(root_wr), .glob_en(glob_en), .inv_valid(inv_valid), .inv_va(inv_va)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; glob_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Expected physical address, written from the requirement text.
  function automatic logic [31:0] exp_pa(input logic [19:0] frm, input logic [31:0] va, input bit big);
    if (big) return ({12'h0, frm} & 32'h000F_FC00) << 12 | (va & 32'h003F_FFFF);
    else     return ({12'h0, frm} << 12) | (va & 32'h0000_0FFF);
  endfunction

  task automatic look_hit(input logic [31:0] va, input logic [19:0] frm, input logic [2:0] pm,
                          input bit big, input string req);
    @(negedge clk); lk_valid = 1'b1; lk_va = va;
    @(negedge clk); lk_valid = 1'b0;
    chk(rsp_valid && rsp_hit, req, {62'h0, rsp_valid, rsp_hit}, 64'h3);
    chk(rsp_paddr == exp_pa(frm, va, big), req, {32'h0, rsp_paddr}, {32'h0, exp_pa(frm, va, big)});
    chk(rsp_perm == pm, req, {61'h0, rsp_perm}, {61'h0, pm});
  endtask

  task automatic look_miss(input logic [31:0] va, input string req);
    @(negedge clk); lk_valid = 1'b1; lk_va = va;
    @(negedge clk); lk_valid = 1'b0;
    chk(rsp_valid && !rsp_hit, req, {62'h0, rsp_valid, rsp_hit}, 64'h2);
  endtask

  task automatic set_fill(input logic [31:0] va, input logic [19:0] frm, input logic [2:0] pm,
                          input bit big, input bit glb);
    fill_valid = 1'b1; fill_vpn = va[31:12]; fill_frame = frm;
    fill_perm = pm; fill_large = big; fill_global = glb;
  endtask

  task automatic fill(input logic [31:0] va, input logic [19:0] frm, input logic [2:0] pm,
                      input bit big, input bit glb);
    @(negedge clk); set_fill(va, frm, pm, big, glb);
    @(negedge clk); fill_valid = 1'b0;
  endtask

  task automatic pulse_root();
    @(negedge clk); root_wr = 1'b1;
    @(negedge clk); root_wr = 1'b0;
  endtask

  task automatic set_ge(input bit v);
    @(negedge clk); glob_en = v;
    @(negedge clk);
  endtask

  task automatic inval(input logic [31:0] va);
    @(negedge clk); inv_valid = 1'b1; inv_va = va;
    @(negedge clk); inv_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(!rsp_valid && !rsp_hit, "R1", {62'h0, rsp_valid, rsp_hit}, 64'h0);
    look_miss(32'h0000_1000, "R1");
  endtask

  task automatic t_basic();
    do_reset();
    look_miss(32'h1234_5678, "R2");
    fill(32'h1234_5000, 20'hABCDE, 3'b101, 1'b0, 1'b0);
    look_hit(32'h1234_5678, 20'hABCDE, 3'b101, 1'b0, "R3");
    look_hit(32'h1234_5FFF, 20'hABCDE, 3'b101, 1'b0, "R5");
    look_miss(32'h1234_6000, "R2");
  endtask

  task automatic t_large();
    do_reset();
    fill(32'h4000_0000, 20'h12345, 3'b011, 1'b1, 1'b0);
    look_hit(32'h403A_BCDE, 20'h12345, 3'b011, 1'b1, "R4");
    chk(rsp_large == 1'b1, "R4", {63'h0, rsp_large}, 64'h1);
    look_miss(32'h4040_0000, "R4");
  endtask

  task automatic t_root();
    do_reset();
    fill(32'h0001_0000, 20'h00011, 3'b001, 1'b0, 1'b1);
    fill(32'h0002_0000, 20'h00022, 3'b010, 1'b0, 1'b0);
    pulse_root();
    look_hit(32'h0001_0004, 20'h00011, 3'b001, 1'b0, "R6");
    look_miss(32'h0002_0004, "R6");
  endtask

  task automatic t_gclear();
    do_reset();
    fill(32'h0001_0000, 20'h00011, 3'b001, 1'b0, 1'b1);
    fill(32'h0002_0000, 20'h00022, 3'b010, 1'b0, 1'b0);
    set_ge(1'b0);
    look_miss(32'h0001_0000, "R7");
    look_hit(32'h0002_0000, 20'h00022, 3'b010, 1'b0, "R7");
    set_ge(1'b1);
  endtask

  task automatic t_gdisabled();
    do_reset();
    set_ge(1'b0);
    fill(32'h0003_0000, 20'h00033, 3'b100, 1'b0, 1'b1);
    set_ge(1'b1);
    look_hit(32'h0003_0000, 20'h00033, 3'b100, 1'b0, "R8");
    pulse_root();
    look_miss(32'h0003_0000, "R8");
  endtask

  task automatic t_fullflush();
    do_reset();
    fill(32'h0001_0000, 20'h00011, 3'b001, 1'b0, 1'b1);
    fill(32'h0002_0000, 20'h00022, 3'b010, 1'b0, 1'b0);
    set_ge(1'b0);
    pulse_root();
    set_ge(1'b1);
    look_miss(32'h0001_0000, "R9");
    look_miss(32'h0002_0000, "R9");
  endtask

  task automatic t_inv();
    do_reset();
    fill(32'h0005_0000, 20'h00055, 3'b001, 1'b0, 1'b0);
    fill(32'h0005_1000, 20'h00056, 3'b001, 1'b0, 1'b1);
    inval(32'h0005_0ABC);
    look_miss(32'h0005_0000, "R10");
    look_hit(32'h0005_1000, 20'h00056, 3'b001, 1'b0, "R10");
  endtask

  task automatic t_inv_large();
    do_reset();
    fill(32'h8000_0000, 20'h77777, 3'b110, 1'b1, 1'b1);
    fill(32'h8040_0000, 20'h00088, 3'b001, 1'b0, 1'b0);
    inval(32'h8023_4567);
    look_miss(32'h8000_0000, "R11");
    look_hit(32'h8040_0000, 20'h00088, 3'b001, 1'b0, "R11");
  endtask

  task automatic t_race();
    do_reset();
    @(negedge clk);
    set_fill(32'h0009_0000, 20'h00099, 3'b001, 1'b0, 1'b1);
    inv_valid = 1'b1; inv_va = 32'h0009_0010;
    @(negedge clk); fill_valid = 1'b0; inv_valid = 1'b0;
    look_miss(32'h0009_0000, "R12");
    @(negedge clk);
    set_fill(32'h000A_0000, 20'h000AA, 3'b010, 1'b0, 1'b0);
    inv_valid = 1'b1; inv_va = 32'h000B_0000;
    @(negedge clk); fill_valid = 1'b0; inv_valid = 1'b0;
    look_hit(32'h000A_0000, 20'h000AA, 3'b010, 1'b0, "R12");
  endtask

  task automatic t_rr();
    do_reset();
    for (int i = 0; i < 9; i++)
      fill(32'h0100_0000 + (i << 12), 20'h00100 + 20'(i), 3'b001, 1'b0, 1'b0);
    look_miss(32'h0100_0000, "R13");
    look_hit(32'h0100_1000, 20'h00101, 3'b001, 1'b0, "R13");
    look_hit(32'h0100_8000, 20'h00108, 3'b001, 1'b0, "R13");
  endtask

  task automatic t_refill();
    do_reset();
    fill(32'h0200_0000, 20'h0AAAA, 3'b001, 1'b0, 1'b0);
    fill(32'h0200_0000, 20'h05555, 3'b010, 1'b0, 1'b0);
    look_hit(32'h0200_0000, 20'h05555, 3'b010, 1'b0, "R14");
    for (int i = 1; i < 8; i++)
      fill(32'h0300_0000 + (i << 12), 20'h00300 + 20'(i), 3'b001, 1'b0, 1'b0);
    look_hit(32'h0200_0000, 20'h05555, 3'b010, 1'b0, "R14");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_large();
    t_root();
    t_gclear();
    t_gdisabled();
    t_fullflush();
    t_inv();
    t_inv_large();
    t_race();
    t_rr();
    t_refill();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule